// File: doc/BRIEF.md
# Serial Memory Status and Write-Protect Controller

This block holds the status byte of a small serial non-volatile memory and decides which decoded write instructions may run. A front-end decoder feeds it single-cycle instruction strobes: enable writes, disable writes, read status, write status, data write, identification write and identification lock. It also receives the level of the active-low write-protect pin. The block answers a status read with the status byte one cycle later. For each write-type instruction it accepts, it gives a start pulse to the array logic and keeps a busy flag set for a fixed, parameterised number of clock cycles.

The protection bits (a status-lock bit and two block-protect bits) stand in for non-volatile cells, so they sit in registers that reset does not touch. Reset clears only the busy flag and the write-enable latch. A status write is refused when the status-lock bit is 1 and the protect pin is driven low. A status write that is accepted takes effect in the protection bits when its write cycle ends. At most one instruction strobe is asserted in any cycle.

Top module: `nvm_status_top`

## Requirements
- R1: The status byte is laid out as bit 7 = status-lock, bits 6..4 = 0, bit 3 = block-protect high, bit 2 = block-protect low, bit 1 = write-enable latch, bit 0 = busy. A read-status strobe in cycle N sets `statusData` to the byte as it stood in cycle N and raises `statusValid` for cycle N+1 only.
- R2: Bits 6..4 of the status byte read 0 whatever value a status write carries.
- R3: When the block is idle, the write-enable strobe sets the write-enable latch.
- R4: When the block is idle, the write-disable strobe clears the write-enable latch.
- R5: A write-type strobe (status write, data write, identification write, identification lock) seen while the latch is 0 starts no cycle, gives no `writeGo` pulse and changes no status bit.
- R6: An accepted write-type strobe in cycle N pulses `writeGo` in cycle N+1 and holds busy at 1 for exactly `WCYCLES` cycles, from N+1 through N+`WCYCLES`.
- R7: The write-enable latch stays 1 while busy and reads 0 once the write cycle ends.
- R8: A status write issued while status-lock = 1 and `wpN` = 0 leaves the protection bits unchanged, starts no cycle and keeps the latch at 1.
- R9: An accepted status write loads bits 7, 3 and 2 of `wrData` into status-lock and the block-protect bits when its write cycle ends, and not before. Data, identification and lock writes leave these bits alone.
- R10: While busy, every strobe except read-status is ignored. A write-type strobe in the last busy cycle also starts nothing. Read-status is served during busy.
- R11: Reset clears the busy flag and the latch and leaves status-lock and the block-protect bits as they were, even when it arrives in the middle of a write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low power-up reset |
| cmdWrEn | input | 1 | Write-enable instruction strobe |
| cmdWrDis | input | 1 | Write-disable instruction strobe |
| cmdRdStat | input | 1 | Read-status instruction strobe |
| cmdWrStat | input | 1 | Write-status instruction strobe |
| cmdDataWr | input | 1 | Data write instruction strobe |
| cmdIdWr | input | 1 | Identification write instruction strobe |
| cmdIdLock | input | 1 | Identification lock instruction strobe |
| wrData | input | 8 | Byte carried by a status write |
| wpN | input | 1 | Write-protect pin, active low |
| statusData | output | 8 | Status byte captured by the last read |
| statusValid | output | 1 | One-cycle pulse when statusData is fresh |
| writeGo | output | 1 | One-cycle pulse when a write cycle starts |

## Verification
The write-gating function is driven through a vector table that runs each write-type instruction with the latch clear and with it set. Status writes are tried with the protect pin high and low, and with the status-lock bit set and clear. This tells apart gating by the latch, gating by the lock/pin pair, and the kinds of write that do not touch the protection bits. Separate directed runs poll the status byte on every cycle of a write cycle. They count the busy cycles, watch the latch in each cycle, and inject a status write in the middle of the cycle and a data write in its last cycle. Other runs reset the block during a write cycle and after the protection bits have been set, to show which bits survive.

// File: rtl/nvm_status_pkg.sv
package nvm_status_pkg;

  localparam int unsigned STAT_W   = 8;
  localparam int unsigned LOCK_POS = 7;
  localparam int unsigned WEL_POS  = 1;
  localparam int unsigned WIP_POS  = 0;

  // bits backed by non-volatile cells: status-lock and the two block-protect bits
  localparam logic [STAT_W-1:0] NV_MASK = 8'b1000_1100;

  typedef struct packed {
    logic captureStat; // latch incoming status byte for a pending update
    logic commitStat;  // move pending byte into the protection bits
    logic loadRead;    // snapshot the status byte for the reader
  } dpStrobe_t;

endpackage

// File: rtl/nvm_status_ctrl.sv
module nvm_status_ctrl
  import nvm_status_pkg::*;
#(
  parameter int unsigned WCYCLES = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      cmdWrEn,
  input  logic      cmdWrDis,
  input  logic      cmdRdStat,
  input  logic      cmdWrStat,
  input  logic      cmdDataWr,
  input  logic      cmdIdWr,
  input  logic      cmdIdLock,
  input  logic      wpN,
  input  logic      lockNow,
  output logic      wel,
  output logic      wip,
  output logic      writeGo,
  output dpStrobe_t strb
);

  localparam int unsigned CNT_W = (WCYCLES > 1) ? $clog2(WCYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WCYCLES - 1);

  logic [CNT_W-1:0] cnt;
  logic statPending;
  logic statLocked;
  logic otherWrite;
  logic accept;
  logic cycleDone;

  assign statLocked = lockNow & ~wpN;
  assign otherWrite = cmdDataWr | cmdIdWr | cmdIdLock;
  assign accept     = !wip && wel && (otherWrite || (cmdWrStat && !statLocked));
  assign cycleDone  = wip && (cnt == '0);

  always_comb begin
    strb.captureStat = accept && cmdWrStat;
    strb.commitStat  = cycleDone && statPending;
    strb.loadRead    = cmdRdStat;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wip         <= 1'b0;
      cnt         <= '0;
      wel         <= 1'b0;
      writeGo     <= 1'b0;
      statPending <= 1'b0;
    end else begin
      writeGo <= accept;
      if (accept) begin
        wip         <= 1'b1;
        cnt         <= CNT_LOAD;
        statPending <= cmdWrStat;
      end else if (cycleDone) begin
        wip         <= 1'b0;
        wel         <= 1'b0;
        statPending <= 1'b0;
      end else if (wip) begin
        cnt <= cnt - 1'b1;
      end else if (cmdWrEn) begin
        wel <= 1'b1;
      end else if (cmdWrDis) begin
        wel <= 1'b0;
      end
    end
  end

  // R6: busy only starts from a strobe that saw the latch set and the block idle
  p_start_needs_wel_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wip) |-> $past(wel) && $past(!wip));

  // R7: latch must be clear once busy drops
  p_wel_cleared_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wip) |-> !wel);

  // R10: nothing disturbs busy or the latch before the counter runs out
  p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (wip && cnt != '0) |=> wip && wel);

  p_go_with_busy_r6: assert property (@(posedge clk) disable iff (!rstN)
    writeGo |-> wip);

endmodule

// File: rtl/nvm_status_dp.sv
module nvm_status_dp
  import nvm_status_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [STAT_W-1:0] wrData,
  input  logic              wel,
  input  logic              wip,
  output logic              lockNow,
  output logic [STAT_W-1:0] statusData,
  output logic              statusValid
);

  // stand-ins for non-volatile cells: deliberately outside the reset domain
  logic [STAT_W-1:0] nvByte;
  logic [STAT_W-1:0] pendByte;
  logic [STAT_W-1:0] liveByte;

  always_ff @(posedge clk) begin
    if (strb.captureStat) pendByte <= wrData & NV_MASK;
    if (strb.commitStat)  nvByte   <= pendByte;
  end

  assign lockNow = nvByte[LOCK_POS];

  always_comb begin
    liveByte          = nvByte & NV_MASK;
    liveByte[WEL_POS] = wel;
    liveByte[WIP_POS] = wip;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusData  <= '0;
      statusValid <= 1'b0;
    end else begin
      statusValid <= strb.loadRead;
      if (strb.loadRead) statusData <= liveByte;
    end
  end

  p_zero_bits_r2: assert property (@(posedge clk) disable iff (!rstN)
    statusValid |-> statusData[6:4] == 3'b000);

  p_valid_pulse_r1: assert property (@(posedge clk) disable iff (!rstN)
    statusValid |-> $past(strb.loadRead));

  p_nv_stable_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commitStat |=> $stable(nvByte & NV_MASK));

endmodule

// File: rtl/nvm_status_top.sv
module nvm_status_top
  import nvm_status_pkg::*;
#(
  parameter int unsigned WCYCLES = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdWrEn,
  input  logic       cmdWrDis,
  input  logic       cmdRdStat,
  input  logic       cmdWrStat,
  input  logic       cmdDataWr,
  input  logic       cmdIdWr,
  input  logic       cmdIdLock,
  input  logic [7:0] wrData,
  input  logic       wpN,
  output logic [7:0] statusData,
  output logic       statusValid,
  output logic       writeGo
);

  dpStrobe_t strb;
  logic wel;
  logic wip;
  logic lockNow;

  nvm_status_ctrl #(.WCYCLES(WCYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .cmdWrEn(cmdWrEn), .cmdWrDis(cmdWrDis), .cmdRdStat(cmdRdStat),
    .cmdWrStat(cmdWrStat), .cmdDataWr(cmdDataWr), .cmdIdWr(cmdIdWr),
    .cmdIdLock(cmdIdLock), .wpN(wpN), .lockNow(lockNow),
    .wel(wel), .wip(wip), .writeGo(writeGo), .strb(strb)
  );

  nvm_status_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .wel(wel), .wip(wip), .lockNow(lockNow),
    .statusData(statusData), .statusValid(statusValid)
  );

endmodule

// File: tb/tb_nvm_status_top.sv
module tb_nvm_status_top;

  localparam int unsigned WC = 8;
  localparam int NVEC = 15;
  // op: 0 none, 1 enable, 2 disable, 3 status write, 4 data write, 5 id write, 6 id lock
  // fields: op[20:18] data[17:10] wp[9] expected status[8:1] expected go[0]
  localparam logic [20:0] VEC [NVEC] = '{
    {3'd3, 8'hFF, 1'b1, 8'h00, 1'b0},
    {3'd1, 8'h00, 1'b1, 8'h02, 1'b0},
    {3'd2, 8'h00, 1'b1, 8'h00, 1'b0},
    {3'd1, 8'h00, 1'b1, 8'h02, 1'b0},
    {3'd3, 8'hFF, 1'b1, 8'h8C, 1'b1},
    {3'd1, 8'h00, 1'b1, 8'h8E, 1'b0},
    {3'd3, 8'h00, 1'b0, 8'h8E, 1'b0},
    {3'd4, 8'h00, 1'b0, 8'h8C, 1'b1},
    {3'd1, 8'h00, 1'b1, 8'h8E, 1'b0},
    {3'd3, 8'h04, 1'b1, 8'h04, 1'b1},
    {3'd1, 8'h00, 1'b1, 8'h06, 1'b0},
    {3'd5, 8'hFF, 1'b1, 8'h04, 1'b1},
    {3'd1, 8'h00, 1'b1, 8'h06, 1'b0},
    {3'd6, 8'hFF, 1'b1, 8'h04, 1'b1},
    {3'd4, 8'h00, 1'b1, 8'h04, 1'b0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdWrEn = 1'b0, cmdWrDis = 1'b0, cmdRdStat = 1'b0, cmdWrStat = 1'b0;
  logic cmdDataWr = 1'b0, cmdIdWr = 1'b0, cmdIdLock = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic wpN = 1'b1;
  logic [7:0] statusData;
  logic statusValid;
  logic writeGo;

  int checks = 0;
  int fails = 0;
  int goCnt = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  nvm_status_top #(.WCYCLES(WC)) dut (
    .clk(clk), .rstN(rstN), .cmdWrEn(cmdWrEn), .cmdWrDis(cmdWrDis),
    .cmdRdStat(cmdRdStat), .cmdWrStat(cmdWrStat), .cmdDataWr(cmdDataWr),
    .cmdIdWr(cmdIdWr), .cmdIdLock(cmdIdLock), .wrData(wrData), .wpN(wpN),
    .statusData(statusData), .statusValid(statusValid), .writeGo(writeGo)
  );

  always @(posedge clk) begin
    cycles++;
    if (writeGo === 1'b1) goCnt++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: actual cycles=%0d expected under 100000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic clearStrobes();
    cmdWrEn = 0; cmdWrDis = 0; cmdWrStat = 0;
    cmdDataWr = 0; cmdIdWr = 0; cmdIdLock = 0;
  endtask

  task automatic doOp(input int op, input logic [7:0] d, input logic wp);
    @(negedge clk);
    wpN = wp; wrData = d;
    case (op)
      1: cmdWrEn = 1;
      2: cmdWrDis = 1;
      3: cmdWrStat = 1;
      4: cmdDataWr = 1;
      5: cmdIdWr = 1;
      6: cmdIdLock = 1;
      default: ;
    endcase
    @(negedge clk);
    clearStrobes();
  endtask

  task automatic readStat(output logic [7:0] v);
    @(negedge clk);
    cmdRdStat = 1;
    @(negedge clk);
    cmdRdStat = 0;
    v = statusData;
  endtask

  task automatic settle();
    repeat (WC + 2) @(negedge clk);
  endtask

  initial begin
    logic [7:0] s;
    int goBefore;
    int ones;
    repeat (3) @(negedge clk);
    check("R11 reset statusValid low", statusValid, 0);
    rstN = 1;
    readStat(s);
    check("R11 latch and busy clear after reset", s & 8'h73, 8'h00);
    check("R1 statusValid pulse high", statusValid, 1);
    @(negedge clk);
    check("R1 statusValid pulse one cycle", statusValid, 0);

    // put the protection bits in a known state
    doOp(1, 8'h00, 1'b1);
    doOp(3, 8'h00, 1'b1);
    settle();

    for (int i = 0; i < NVEC; i++) begin
      goBefore = goCnt;
      doOp(int'(VEC[i][20:18]), VEC[i][17:10], VEC[i][9]);
      settle();
      readStat(s);
      check($sformatf("R1 R2 R3 R4 R5 R7 R8 R9 vector %0d status", i), s, VEC[i][8:1]);
      check($sformatf("R5 R6 R8 vector %0d write start count", i), goCnt - goBefore, VEC[i][0]);
    end

    // R6 R7 R10: poll busy every cycle, disturb it mid-cycle and in its last cycle
    doOp(1, 8'h00, 1'b1);
    goBefore = goCnt;
    doOp(4, 8'h00, 1'b1);
    cmdRdStat = 1;
    ones = 0;
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk);
      clearStrobes();
      if (statusData[0]) begin
        ones++;
        check($sformatf("R7 latch held in busy cycle %0d", k), statusData[1], 1);
      end
      if (k == 3) begin cmdWrStat = 1; wrData = 8'h80; end
      if (k == 5) cmdWrDis = 1;
      if (k == 7) cmdDataWr = 1;
      if (k == 9) check("R7 latch clear after cycle", statusData[1], 0);
    end
    cmdRdStat = 0;
    check("R6 busy length", ones, WC);
    check("R10 single start despite strobes while busy", goCnt - goBefore, 1);
    settle();
    readStat(s);
    check("R10 status write during busy ignored", s, 8'h04);

    // R11: protection bits survive reset, also when reset hits a write cycle
    doOp(1, 8'h00, 1'b1);
    doOp(3, 8'h88, 1'b1);
    settle();
    readStat(s);
    check("R9 lock and high protect bit set", s, 8'h88);
    doOp(1, 8'h00, 1'b1);
    doOp(4, 8'h00, 1'b0);
    repeat (3) @(negedge clk);
    rstN = 0;
    @(negedge clk);
    rstN = 1;
    readStat(s);
    check("R11 reset mid-cycle keeps protect bits, clears busy", s, 8'h88);
    doOp(1, 8'h00, 1'b0);
    readStat(s);
    check("R3 enable accepted right after reset", s, 8'h8A);
    doOp(3, 8'h00, 1'b1);
    settle();
    readStat(s);
    check("R8 pin high lets locked status be rewritten", s, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule